// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the host end of a serial interrupt wire: one open-drain line, pulled high, shared by the host and its peripherals and clocked by the PCI clock. The host opens each polling cycle with a start frame. It then walks a run of three-clock data frames. In each one it samples the wire on the first clock, and a low there means the peripheral that owns the slot is asserting its interrupt. The samples are turned into held request levels: the legacy IRQ lines, a system-management interrupt, a channel-check flag and the four PCI interrupts.

The cycle ends with a stop frame, and its length announces the next mode. In continuous mode the host keeps polling on its own. In quiet mode the wire stays idle until a peripheral pulls it low. The host treats that as the first clock of a start frame and finishes driving it. The mode, the start-frame length and the number of data frames come from register inputs. `sirq_drive_low` enables the pad's low driver. `sirq_in` is the level seen on the pad.

Top module: `sirq_host`

## Requirements
- R1: While `rst_n` is low, the wire is released, every request output is inactive and `smi_n` is high. The first start frame is driven from the second rising edge after `rst_n` goes high.
- R2: A start frame keeps the wire low for 4 clocks when `start_len_sel` is 0, 6 when it is 1, and 8 when it is 2 or 3. It is followed by one released turnaround clock.
- R3: Clock 1 is the first clock after the start frame's low clocks. Data frame N is sampled on clock 3N−1, and a low sample means active.
- R4: Frame-to-output map (all active high except `smi_n`):
  - frame N drives `irq_req[N-1]` for N = 2, 4..8, 10..13, 15, 16;
  - frame 17 drives `iochk_req`;
  - frames 18..21 drive `pci_int_req[0..3]`;
  - `irq_req` bits 0, 2, 8 and 13 are always 0.
- R5: `smi_n` is low exactly while the last sample of frame 3 was low.
- R6: A low sample in frame 1, 9, 14 or any frame from 22 to 32 changes no output.
- R7: Each output holds its value until its own frame is sampled again. A frame beyond the programmed count is not sampled, so its output holds.
- R8: `frame_total` sets the number of data frames. Values below 17 act as 17 and values above 32 act as 32. The stop frame starts on clock 3·count+2.
- R9: The stop frame is 2 clocks low if `quiet_sel` is high on its first clock, and 3 clocks low otherwise.
- R10: After a 3-clock stop frame, the wire stays released for exactly 2 clocks, and then the host drives the next start frame.
- R11: After a 2-clock stop frame, the host never starts on its own. A low on either of the two clocks right after the stop frame is ignored. A later low is taken as a peripheral's start frame, which the host continues so that the whole start frame lasts the R2 length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous reset, active low |
| quiet_sel | input | 1 | 1 selects quiet mode for the next stop frame |
| start_len_sel | input | 2 | Start-frame length select |
| frame_total | input | 6 | Number of data frames (17..32) |
| sirq_in | input | 1 | Wire level seen at the pad |
| sirq_drive_low | output | 1 | Enables the pad's low driver |
| irq_req | output | 16 | Legacy IRQ requests, bit n = IRQn |
| smi_n | output | 1 | System-management interrupt, active low |
| iochk_req | output | 1 | Channel-check request |
| pci_int_req | output | 4 | PCI INTA..INTD requests, bit 0 = INTA |

## Verification
A peripheral model pulls the wire low on the sample clock of every frame whose bit is set, under several patterns:
- Only the unassigned slots low: shows that they are ignored.
- Every assigned slot low: catches a wrong slot or an off-by-one sample clock.
- Alternating and sparse patterns: separate neighbouring frames from each other.
- A short frame count after a long one: shows that unsampled outputs hold.

Clamped counts of 5 and 40 exercise the frame-count bound. Quiet cycles add an early peripheral pull that must be ignored, then a valid one that must start the next cycle. A reset in the middle of the data frames shows that the outputs clear.

// File: rtl/sirq_host.sv
`timescale 1ns/1ps
module sirq_host #(
  parameter int FRAMES_MIN = 17,
  parameter int FRAMES_MAX = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        quiet_sel,
  input  logic [1:0]  start_len_sel,
  input  logic [5:0]  frame_total,
  input  logic        sirq_in,
  output logic        sirq_drive_low,
  output logic [15:0] irq_req,
  output logic        smi_n,
  output logic        iochk_req,
  output logic [3:0]  pci_int_req
);

  localparam int SLOTS = 21;

  typedef enum logic [2:0] {REC, IDLE, START, DATA, STOP} state_t;

  state_t         st;
  logic [3:0]     cnt;
  logic [5:0]     fn;
  logic [1:0]     ph;
  logic           quiet_q;
  logic [SLOTS:1] act;
  logic [3:0]     start_w, stop_w;
  logic [5:0]     last_fn;
  logic           sample_now, in_data, in_idle;

  assign start_w = (start_len_sel == 2'd0) ? 4'd4 :
                   (start_len_sel == 2'd1) ? 4'd6 : 4'd8;
  assign stop_w  = quiet_q ? 4'd2 : 4'd3;
  assign last_fn = (frame_total < 6'(FRAMES_MIN)) ? 6'(FRAMES_MIN) :
                   (frame_total > 6'(FRAMES_MAX)) ? 6'(FRAMES_MAX) : frame_total;

  assign in_data        = (st == DATA);
  assign in_idle        = (st == IDLE);
  assign sample_now     = in_data && (ph == 2'd0);
  assign sirq_drive_low = (st == START) || (st == STOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= REC;
      cnt     <= '0;
      fn      <= '0;
      ph      <= '0;
      quiet_q <= 1'b0;
      act     <= '0;
    end else begin
      case (st)
        REC:
          if (cnt == 4'd1) begin
            cnt <= '0;
            st  <= quiet_q ? IDLE : START;
          end else cnt <= cnt + 4'd1;
        IDLE:
          if (!sirq_in) begin
            st  <= START;
            cnt <= 4'd1;
          end
        START:
          if (cnt == start_w - 4'd1) begin
            st  <= DATA;
            cnt <= '0;
            fn  <= '0;
            ph  <= 2'd2;
          end else cnt <= cnt + 4'd1;
        DATA:
          if (ph == 2'd2) begin
            if (fn == last_fn) begin
              st      <= STOP;
              quiet_q <= quiet_sel;
            end else begin
              fn <= fn + 6'd1;
              ph <= 2'd0;
            end
          end else ph <= ph + 2'd1;
        STOP:
          if (cnt == stop_w - 4'd1) begin
            st  <= REC;
            cnt <= '0;
          end else cnt <= cnt + 4'd1;
        default: st <= REC;
      endcase
      for (int k = 1; k <= SLOTS; k++)
        if (sample_now && fn == 6'(k)) act[k] <= ~sirq_in;
    end
  end

  assign irq_req     = {act[16], act[15], 1'b0, act[13:10], 1'b0, act[8:4], 1'b0, act[2], 1'b0};
  assign smi_n       = ~act[3];
  assign iochk_req   = act[17];
  assign pci_int_req = act[21:18];

endmodule

// File: rtl/sirq_host_chk.sv
`timescale 1ns/1ps
module sirq_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sirq_in,
  input logic        sirq_drive_low,
  input logic [15:0] irq_req,
  input logic        smi_n,
  input logic        iochk_req,
  input logic [3:0]  pci_int_req,
  input logic        sample_now,
  input logic        in_data,
  input logic        in_idle,
  input logic        quiet_q,
  input logic [5:0]  fn
);

  logic [4:0] drive_run;

  always_ff @(posedge clk) begin
    if (!rst_n) drive_run <= '0;
    else if (sirq_drive_low) drive_run <= drive_run + 5'd1;
    else drive_run <= '0;
  end

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({irq_req, iochk_req, pci_int_req}) |-> $past(sample_now));

  p_smi_frame3_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(smi_n) |-> $past(sample_now && fn == 6'd3));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && sirq_in) |=> !sirq_drive_low);

  p_stop_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sirq_drive_low) && !in_data) |-> (drive_run == (quiet_q ? 5'd2 : 5'd3)));

endmodule

bind sirq_host sirq_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sirq_in(sirq_in), .sirq_drive_low(sirq_drive_low),
  .irq_req(irq_req), .smi_n(smi_n), .iochk_req(iochk_req), .pci_int_req(pci_int_req),
  .sample_now(sample_now), .in_data(in_data), .in_idle(in_idle),
  .quiet_q(quiet_q), .fn(fn)
);

// File: tb/tb_sirq_host.sv
`timescale 1ns/1ps
module tb_sirq_host;

  logic        clk = 1'b0, rst_n = 1'b0, quiet_sel = 1'b0;
  logic [1:0]  wsel = 2'd0;
  logic [5:0]  ftot = 6'd32;
  logic        per_frame = 1'b0, per_kick = 1'b0;
  logic        sirq, drive, smi_n, iochk;
  logic [15:0] irq;
  logic [3:0]  pci;
  logic [31:0] pat = '0;

  assign sirq = ~(drive | per_frame | per_kick);
  always #4 clk = ~clk;

  sirq_host dut (
    .clk(clk), .rst_n(rst_n), .quiet_sel(quiet_sel), .start_len_sel(wsel),
    .frame_total(ftot), .sirq_in(sirq), .sirq_drive_low(drive),
    .irq_req(irq), .smi_n(smi_n), .iochk_req(iochk), .pci_int_req(pci)
  );

  localparam int NV = 7;
  // {quiet, start sel, frame count, pattern (bit N-1 = frame N pulled low)}
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 2'd0, 6'd32, 32'hFFE0_2101},
    {1'b0, 2'd1, 6'd21, 32'h001F_DEFE},
    {1'b1, 2'd2, 6'd17, 32'h0000_0A52},
    {1'b0, 2'd3, 6'd5,  32'h0001_2345},
    {1'b1, 2'd0, 6'd40, 32'h5555_5555},
    {1'b0, 2'd1, 6'd20, 32'h0000_0000},
    {1'b0, 2'd2, 6'd32, 32'hAAAA_AAAA}
  };

  int checks = 0, fails = 0, cyc = 0;
  logic e [1:32];

  function automatic int wexp(input logic [1:0] s);
    return (s == 2'd0) ? 4 : (s == 2'd1) ? 6 : 8;
  endfunction

  function automatic int fexp(input logic [5:0] f);
    return (f < 6'd17) ? 17 : (f > 6'd32) ? 32 : int'(f);
  endfunction

  function automatic string note(input int i);
    case (i)
      0: return "R6 unassigned only";
      1: return "R3 all assigned";
      2: return "R7 held beyond count";
      3: return "R8 count clamp low";
      4: return "R8 count clamp high";
      5: return "R7 hold frame 21";
      default: return "R3 alternating";
    endcase
  endfunction

  task automatic check(input bit ok, input string msg, input logic [31:0] a, input logic [31:0] x);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", msg, a, x);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk_outputs(input string tag);
    logic [15:0] xi;
    logic [3:0]  xp;
    xi = '0;
    for (int b = 0; b < 16; b++)
      if (b != 0 && b != 2 && b != 8 && b != 13) xi[b] = e[b + 1];
    for (int k = 0; k < 4; k++) xp[k] = e[18 + k];
    check(irq === xi, {"R4 irq ", tag}, 32'(irq), 32'(xi));
    check(smi_n === ~e[3], {"R5 smi ", tag}, 32'(smi_n), 32'(~e[3]));
    check(iochk === e[17], {"R4 iochk ", tag}, 32'(iochk), 32'(e[17]));
    check(pci === xp, {"R4 pci ", tag}, 32'(pci), 32'(xp));
  endtask

  task automatic apply(input int i);
    quiet_sel = VEC[i][40];
    wsel      = VEC[i][39:38];
    ftot      = VEC[i][37:32];
    pat       = VEC[i][31:0];
  endtask

  // wire monitor and peripheral model, acting 1 ns before each rising edge
  int t = 0, lrun = 0, hrun = 0, run_t = 0, stop_cnt = 0;
  bit prev_w = 1'b1, after_cont = 1'b0;

  always begin
    bit pf, w;
    int n;
    @(negedge clk);
    #3;
    if (!rst_n) begin
      t = 0; lrun = 0; hrun = 0; prev_w = 1'b1; after_cont = 1'b0;
      per_frame = 1'b0;
    end else begin
      if (t > 0 && t < 1000) t++;
      if (!prev_w && !drive && lrun >= 4) t = 1;
      pf = 1'b0;
      if (t >= 2 && (t + 1) % 3 == 0) begin
        n = (t + 1) / 3;
        if (n <= fexp(ftot)) pf = pat[n - 1];
      end
      per_frame = pf;
      w = !(drive | pf | per_kick);
      if (!w) begin
        if (prev_w) begin
          if (after_cont) begin
            check(hrun == 2, "R10 released gap before start", 32'(hrun), 32'd2);
            after_cont = 1'b0;
          end
          run_t = t;
          lrun = 1;
        end else lrun++;
      end else begin
        if (!prev_w) begin
          if (lrun >= 4)
            check(lrun == wexp(wsel), "R2 start frame length", 32'(lrun), 32'(wexp(wsel)));
          else if (lrun >= 2) begin
            check(lrun == (quiet_sel ? 2 : 3), "R9 stop frame length",
                  32'(lrun), quiet_sel ? 32'd2 : 32'd3);
            check(run_t == 3 * fexp(ftot) + 2, "R8 stop frame position",
                  32'(run_t), 32'(3 * fexp(ftot) + 2));
            after_cont = !quiet_sel;
            stop_cnt++;
          end
          hrun = 1;
        end else hrun++;
      end
      prev_w = w;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic wait_stop();
    int s, k;
    s = stop_cnt;
    k = 0;
    while (stop_cnt == s && k < 800) begin
      @(negedge clk); #1;
      k++;
    end
    check(stop_cnt != s, "R9 stop frame seen", 32'(stop_cnt), 32'(s + 1));
  endtask

  task automatic quiet_proc();
    bit bad;
    per_kick = 1'b1;                 // second released clock after stop: too early
    @(negedge clk); #1;
    per_kick = 1'b0;
    bad = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      if (drive) bad = 1'b1;
    end
    check(!bad, "R11 host stays released in quiet idle", 32'(bad), 32'd0);
    per_kick = 1'b1;
    @(negedge clk); #1;
    per_kick = 1'b0;
    check(drive === 1'b1, "R11 host continues peripheral start", 32'(drive), 32'd1);
  endtask

  initial begin
    for (int n = 1; n <= 32; n++) e[n] = 1'b0;
    apply(0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(drive === 1'b0, "R1 wire released in reset", 32'(drive), 32'd0);
    chk_outputs("R1 reset");
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(drive === 1'b0, "R1 released first clock", 32'(drive), 32'd0);
    @(negedge clk); #1;
    check(drive === 1'b1, "R1 first start frame", 32'(drive), 32'd1);

    for (int i = 0; i < NV; i++) begin
      wait_stop();
      for (int n = 1; n <= fexp(VEC[i][37:32]); n++) e[n] = VEC[i][n - 1];
      chk_outputs(note(i));
      if (i < NV - 1) apply(i + 1);
      if (VEC[i][40]) quiet_proc();
    end

    begin
      int k;
      k = 0;
      while (t != 20 && k < 400) begin
        @(negedge clk); #1;
        k++;
      end
    end
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    for (int n = 1; n <= 32; n++) e[n] = 1'b0;
    check(drive === 1'b0, "R1 mid-frame reset releases wire", 32'(drive), 32'd0);
    chk_outputs("R1 mid-frame reset");
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(drive === 1'b0, "R1 released after reset", 32'(drive), 32'd0);
    @(negedge clk); #1;
    check(drive === 1'b1, "R1 start after reset", 32'(drive), 32'd1);
    wait_stop();
    for (int n = 1; n <= 32; n++) e[n] = VEC[NV - 1][n - 1];
    chk_outputs("R3 after reset");

    summary();
    $finish;
  end

endmodule